// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a small single-cycle processor for a subset of a 32-bit load-store instruction set. It executes register-register add, sub, and and or, immediate add, word load and word store. Each clock edge retires one instruction. The program counter addresses an internal instruction array. The register file feeds a four-operation ALU. A write-back multiplexer picks the value written to the destination register. The data array is read and written at an address that the ALU computes.

Control is produced by slicing every instruction word into all of its possible fields in parallel. The opcode and funct fields are then decoded into one-hot instruction lines. Every select and write enable comes from those lines. The 2-bit ALU operation comes from a priority chain that falls back to AND.

The instruction array is filled through a load port, normally while reset is held. Register and data-memory updates are visible at the ports: one strobe reports the register write that commits at the coming edge, and another reports the store that commits at the coming edge.

Top module: `lsc_core`

## Requirements
- R1: Every instruction word is split into fields at fixed positions: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shift amount [10:6], funct [5:0], immediate [15:0]. An instruction ignores the fields it does not use.
- R2: Opcode encodings are as follows. 0x00 is register-register, with funct 0x20 add, 0x22 sub, 0x24 and and 0x25 or. 0x08 is addi, 0x23 is lw and 0x2B is sw. Any other opcode, and any other funct under opcode 0x00, neither writes a register nor stores.
- R3: A register-register instruction writes rd with rs combined with rt by the selected operation. Sub gives rs minus rt, modulo 2^32.
- R4: addi writes rt with rs plus the sign-extended immediate. The word 0x2210FFFF decrements register 16 by one.
- R5: lw writes rt with the data word at index bits [7:2] of (rs + sign-extended immediate). The index wraps modulo the 64-word data array.
- R6: sw writes the value of rt into the data word at the address formed as in R5. It raises st_en with that address on st_addr and the value on st_data, and it never writes a register.
- R7: Register 0 always reads zero. An instruction whose destination is register 0 commits nothing and leaves wb_en low.
- R8: The PC advances by 4 on every clock edge outside reset, whatever instruction executes. The instruction is fetched from array word pc[7:2].
- R9: Synchronous active-high reset clears the PC, all registers and all data words. While rst is high, wb_en and st_en stay low.
- R10: While wb_en is high, wb_idx and wb_data give the register and the value that the next rising edge writes. A later read of that register returns the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Instruction array write strobe |
| prog_addr | input | 6 | Instruction array word index |
| prog_data | input | 32 | Instruction word to store |
| pc | output | 32 | Address of the instruction now executing |
| wb_en | output | 1 | A register write commits at the next edge |
| wb_idx | output | 5 | Destination register of that write |
| wb_data | output | 32 | Value of that write |
| st_en | output | 1 | A data store commits at the next edge |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Word stored |

## Verification
The bound checker checks on every cycle the behaviours that hold for any instruction. These are the 4-byte PC step, reset forcing the PC to zero, silence of both strobes during reset, a store never raising a register write, no commit to register 0, and at most one decoded instruction line at a time. The values written depend on the register and memory history. Only the bench's reference interpreter can confirm them. It runs pseudo-random programs that mix every opcode with invalid encodings, wrapping addresses and register 0 destinations, and it also checks the decrement word directly.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

   typedef enum logic [1:0] {
      ALU_AND = 2'd0,
      ALU_OR  = 2'd1,
      ALU_ADD = 2'd2,
      ALU_SUB = 2'd3
   } alu_op_e;

   typedef enum logic [1:0] {
      WB_MEM = 2'd0,
      WB_ALU = 2'd1,
      WB_IMM = 2'd2,
      WB_RET = 2'd3
   } wb_sel_e;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_ADDI  = 6'h08;
   localparam logic [5:0] OP_LW    = 6'h23;
   localparam logic [5:0] OP_SW    = 6'h2B;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;

   // one-hot instruction line positions
   localparam int L_ADD  = 0;
   localparam int L_SUB  = 1;
   localparam int L_AND  = 2;
   localparam int L_OR   = 3;
   localparam int L_ADDI = 4;
   localparam int L_LW   = 5;
   localparam int L_SW   = 6;
   localparam int NLINES = 7;

   typedef struct packed {
      logic [5:0]  op;
      logic [4:0]  rs;
      logic [4:0]  rt;
      logic [4:0]  rd;
      logic [4:0]  sh;
      logic [5:0]  fn;
      logic [15:0] imm;
      logic [25:0] tgt;
   } fields_t;

   typedef struct packed {
      logic    reg_wr;
      logic    mem_wr;
      logic    src_imm;
      logic    dst_rt;
      wb_sel_e wb_sel;
      alu_op_e alu_op;
   } ctrl_t;

endpackage

// File: rtl/lsc_decode.sv
module lsc_decode
   import lsc_pkg::*;
(
   input  logic [31:0]       instr,
   output fields_t           fld,
   output logic [NLINES-1:0] lines,
   output ctrl_t             ctl
);

   logic is_r;

   // all fields sliced at once; consumers pick what they need
   always_comb begin
      fld.op  = instr[31:26];
      fld.rs  = instr[25:21];
      fld.rt  = instr[20:16];
      fld.rd  = instr[15:11];
      fld.sh  = instr[10:6];
      fld.fn  = instr[5:0];
      fld.imm = instr[15:0];
      fld.tgt = instr[25:0];
   end

   assign is_r = (fld.op == OP_RTYPE);

   always_comb begin
      lines         = '0;
      lines[L_ADD]  = is_r && (fld.fn == FN_ADD);
      lines[L_SUB]  = is_r && (fld.fn == FN_SUB);
      lines[L_AND]  = is_r && (fld.fn == FN_AND);
      lines[L_OR]   = is_r && (fld.fn == FN_OR);
      lines[L_ADDI] = (fld.op == OP_ADDI);
      lines[L_LW]   = (fld.op == OP_LW);
      lines[L_SW]   = (fld.op == OP_SW);
   end

   always_comb begin
      ctl.reg_wr  = lines[L_ADD] | lines[L_SUB] | lines[L_AND] | lines[L_OR]
                  | lines[L_ADDI] | lines[L_LW];
      ctl.mem_wr  = lines[L_SW];
      ctl.src_imm = lines[L_ADDI] | lines[L_LW] | lines[L_SW];
      ctl.dst_rt  = lines[L_ADDI] | lines[L_LW];
      ctl.wb_sel  = lines[L_LW] ? WB_MEM : WB_ALU;
      // priority chain, lowest input tied high: AND is the fall-back
      if (lines[L_SUB])
         ctl.alu_op = ALU_SUB;
      else if (lines[L_ADD] | lines[L_ADDI] | lines[L_LW] | lines[L_SW])
         ctl.alu_op = ALU_ADD;
      else if (lines[L_OR])
         ctl.alu_op = ALU_OR;
      else
         ctl.alu_op = ALU_AND;
   end

endmodule

// File: rtl/lsc_alu.sv
module lsc_alu
   import lsc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_op_e         op,
   output logic [XLEN-1:0] y
);

   always_comb begin
      unique case (op)
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/lsc_regfile.sv
module lsc_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int RAW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            we,
   input  logic [RAW-1:0]  wa,
   input  logic [XLEN-1:0] wd,
   input  logic [RAW-1:0]  ra1,
   input  logic [RAW-1:0]  ra2,
   output logic [XLEN-1:0] rd1,
   output logic [XLEN-1:0] rd2
);

   logic [XLEN-1:0] q [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign q[i] = '0;
      end else begin : g_store
         logic [XLEN-1:0] r;
         always_ff @(posedge clk) begin
            if (rst)
               r <= '0;
            else if (we && (wa == RAW'(i)))
               r <= wd;
         end
         assign q[i] = r;
      end
   end

   assign rd1 = q[ra1];
   assign rd2 = q[ra2];

endmodule

// File: rtl/lsc_core.sv
module lsc_core
   import lsc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int NREG       = 32,
   parameter int IMEM_WORDS = 64,
   parameter int DMEM_WORDS = 64,
   localparam int IAW = $clog2(IMEM_WORDS),
   localparam int DAW = $clog2(DMEM_WORDS),
   localparam int RAW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            prog_we,
   input  logic [IAW-1:0]  prog_addr,
   input  logic [31:0]     prog_data,
   output logic [XLEN-1:0] pc,
   output logic            wb_en,
   output logic [RAW-1:0]  wb_idx,
   output logic [XLEN-1:0] wb_data,
   output logic            st_en,
   output logic [XLEN-1:0] st_addr,
   output logic [XLEN-1:0] st_data
);

   // elaboration-time parameter checks
   if (XLEN != 32) begin : g_bad_xlen
      $error("lsc_core: XLEN must be 32");
   end
   if (NREG != 32) begin : g_bad_nreg
      $error("lsc_core: NREG must be 32 to match 5-bit register fields");
   end
   if ((1 << IAW) != IMEM_WORDS || IAW < 1) begin : g_bad_imem
      $error("lsc_core: IMEM_WORDS must be a power of two");
   end
   if ((1 << DAW) != DMEM_WORDS || DAW < 1) begin : g_bad_dmem
      $error("lsc_core: DMEM_WORDS must be a power of two");
   end

   logic [31:0]       imem [IMEM_WORDS];
   logic [XLEN-1:0]   dmem [DMEM_WORDS];
   logic [31:0]       instr;
   fields_t           fld;
   ctrl_t             ctl;
   logic [NLINES-1:0] dec_lines;
   logic [XLEN-1:0]   rs_val, rt_val, imm_ext, opb, alu_y, ld_val, wb_mux;
   logic [RAW-1:0]    dest;
   logic [DAW-1:0]    didx;

   // program counter
   always_ff @(posedge clk) begin
      if (rst)
         pc <= '0;
      else
         pc <= pc + XLEN'(4);
   end

   // instruction array
   always_ff @(posedge clk) begin
      if (prog_we)
         imem[prog_addr] <= prog_data;
   end
   assign instr = imem[pc[IAW+1:2]];

   lsc_decode u_dec (
      .instr (instr),
      .fld   (fld),
      .lines (dec_lines),
      .ctl   (ctl)
   );

   lsc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk (clk),
      .rst (rst),
      .we  (wb_en),
      .wa  (wb_idx),
      .wd  (wb_data),
      .ra1 (fld.rs),
      .ra2 (fld.rt),
      .rd1 (rs_val),
      .rd2 (rt_val)
   );

   assign imm_ext = {{(XLEN-16){fld.imm[15]}}, fld.imm};
   assign opb     = ctl.src_imm ? imm_ext : rt_val;

   lsc_alu #(.XLEN(XLEN)) u_alu (
      .a  (rs_val),
      .b  (opb),
      .op (ctl.alu_op),
      .y  (alu_y)
   );

   // data array
   assign didx   = alu_y[DAW+1:2];
   assign ld_val = dmem[didx];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < DMEM_WORDS; k++)
            dmem[k] <= '0;
      end else if (st_en) begin
         dmem[didx] <= rt_val;
      end
   end

   // write-back select
   always_comb begin
      unique case (ctl.wb_sel)
         WB_MEM:  wb_mux = ld_val;
         WB_ALU:  wb_mux = alu_y;
         WB_IMM:  wb_mux = imm_ext;
         WB_RET:  wb_mux = pc + XLEN'(4);
         default: wb_mux = alu_y;
      endcase
   end

   assign dest    = ctl.dst_rt ? fld.rt : fld.rd;
   assign wb_en   = !rst && ctl.reg_wr && (dest != '0);
   assign wb_idx  = dest;
   assign wb_data = wb_mux;

   assign st_en   = !rst && ctl.mem_wr;
   assign st_addr = alu_y;
   assign st_data = rt_val;

   logic unused_bits;
   assign unused_bits = ^{pc[1:0], pc[XLEN-1:IAW+2], fld.sh, fld.tgt,
                          alu_y[1:0], alu_y[XLEN-1:DAW+2]};

endmodule

// File: rtl/lsc_core_chk.sv
module lsc_core_chk #(
   parameter int XLEN   = 32,
   parameter int RAW    = 5,
   parameter int NLINES = 7
) (
   input logic              clk,
   input logic              rst,
   input logic [XLEN-1:0]   pc,
   input logic              wb_en,
   input logic [RAW-1:0]    wb_idx,
   input logic              st_en,
   input logic [NLINES-1:0] lines
);

   // R8: steady 4-byte step outside reset
   a_r8_pc_step: assert property (@(posedge clk) disable iff (rst)
      !rst |=> pc == $past(pc) + XLEN'(4));

   // R9: reset forces PC to zero
   a_r9_reset_pc: assert property (@(posedge clk)
      rst |=> pc == '0);

   // R9: strobes silent during reset
   a_r9_quiet_reset: assert property (@(posedge clk)
      rst |-> (!wb_en && !st_en));

   // R6: a store never writes a register
   a_r6_store_no_wb: assert property (@(posedge clk) disable iff (rst)
      st_en |-> !wb_en);

   // R7: register 0 is never committed
   a_r7_no_r0_write: assert property (@(posedge clk) disable iff (rst)
      wb_en |-> wb_idx != '0);

   // R2: at most one instruction line decoded
   a_r2_onehot_lines: assert property (@(posedge clk) disable iff (rst)
      $onehot0(lines));

endmodule

bind lsc_core lsc_core_chk #(
   .XLEN   (XLEN),
   .RAW    (RAW),
   .NLINES (lsc_pkg::NLINES)
) u_chk (
   .clk    (clk),
   .rst    (rst),
   .pc     (pc),
   .wb_en  (wb_en),
   .wb_idx (wb_idx),
   .st_en  (st_en),
   .lines  (dec_lines)
);

// File: tb/lsc_core_tb.sv
module lsc_core_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NW         = 64;
   localparam int RUN_CYC    = 200;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        prog_we = 1'b0;
   logic [5:0]  prog_addr = '0;
   logic [31:0] prog_data = '0;
   logic [31:0] pc;
   logic        wb_en;
   logic [4:0]  wb_idx;
   logic [31:0] wb_data;
   logic        st_en;
   logic [31:0] st_addr;
   logic [31:0] st_data;

   int checks = 0;
   int errors = 0;

   logic [31:0] prog [NW];
   logic [31:0] m_rf [32];
   logic [31:0] m_dm [NW];
   logic [31:0] m_pc;

   always #(CLK_PERIOD/2) clk = ~clk;

   lsc_core u_dut (
      .clk       (clk),
      .rst       (rst),
      .prog_we   (prog_we),
      .prog_addr (prog_addr),
      .prog_data (prog_data),
      .pc        (pc),
      .wb_en     (wb_en),
      .wb_idx    (wb_idx),
      .wb_data   (wb_data),
      .st_en     (st_en),
      .st_addr   (st_addr),
      .st_data   (st_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] x);
      logic [31:0] v = x;
      v = v ^ (v << 13);
      v = v ^ (v >> 17);
      v = v ^ (v << 5);
      return v;
   endfunction

   function automatic logic [4:0] pick_reg(input logic [31:0] r);
      return (r[7:4] == 4'hF) ? 5'd16 : {2'b00, r[2:0]};
   endfunction

   // pseudo-random program covering every opcode plus invalid words
   task automatic build_prog(input logic [31:0] seed);
      logic [31:0] s = seed;
      for (int i = 0; i < NW; i++) begin
         logic [4:0] rs, rt, rd;
         logic [15:0] imm;
         logic [5:0] op;
         s = nxt(s);
         rs = pick_reg(s);
         rt = pick_reg(s >> 8);
         rd = pick_reg(s >> 16);
         imm = {{9{s[30]}}, s[29:23]};
         unique case (s[3:0] % 9)
            0: prog[i] = {6'h00, rs, rt, rd, 5'd0, 6'h20};
            1: prog[i] = {6'h00, rs, rt, rd, s[12:8], 6'h22};
            2: prog[i] = {6'h00, rs, rt, rd, 5'd0, 6'h24};
            3: prog[i] = {6'h00, rs, rt, rd, 5'd0, 6'h25};
            4: prog[i] = {6'h08, rs, rt, imm};
            5: prog[i] = {6'h23, rs, rt, imm};
            6: prog[i] = {6'h2B, rs, rt, imm};
            7: prog[i] = {6'h00, rs, rt, rd, 5'd0, 6'h21};
            default: begin
               op = s[29:24];
               if (op == 6'h00 || op == 6'h08 || op == 6'h23 || op == 6'h2B)
                  op = 6'h3F;
               prog[i] = {op, rs, rt, imm};
            end
         endcase
      end
   endtask

   task automatic load_and_reset();
      rst = 1'b1;
      for (int i = 0; i < NW; i++) begin
         prog_we = 1'b1;
         prog_addr = 6'(i);
         prog_data = prog[i];
         @(negedge clk);
      end
      prog_we = 1'b0;
      @(negedge clk);
      #1;
      chk(pc == 32'h0, "R9", "pc in reset", pc, 32'h0);
      chk(!wb_en, "R9", "wb_en in reset", {31'd0, wb_en}, 32'h0);
      chk(!st_en, "R9", "st_en in reset", {31'd0, st_en}, 32'h0);
      for (int k = 0; k < 32; k++) m_rf[k] = '0;
      for (int k = 0; k < NW; k++) m_dm[k] = '0;
      m_pc = '0;
      rst = 1'b0;
      #1;
   endtask

   // reference interpreter for one instruction, compared at the ports
   task automatic step_check();
      logic [31:0] ins, a, b, se, res, addr;
      logic [5:0]  op, fn;
      logic [4:0]  dst;
      bit          wr, st;
      string       tag;
      ins = prog[m_pc[7:2]];
      op  = ins[31:26];
      fn  = ins[5:0];
      a   = m_rf[ins[25:21]];
      b   = m_rf[ins[20:16]];
      se  = {{16{ins[15]}}, ins[15:0]};
      wr = 0; st = 0; res = '0; addr = '0; dst = '0; tag = "R2";
      if (op == 6'h00 && (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25)) begin
         wr = 1; dst = ins[15:11]; tag = "R3";
         res = (fn == 6'h20) ? a + b : (fn == 6'h22) ? a - b :
               (fn == 6'h24) ? (a & b) : (a | b);
      end else if (op == 6'h08) begin
         wr = 1; dst = ins[20:16]; res = a + se; tag = "R4";
      end else if (op == 6'h23) begin
         wr = 1; dst = ins[20:16]; addr = a + se; res = m_dm[addr[7:2]]; tag = "R5";
      end else if (op == 6'h2B) begin
         st = 1; addr = a + se; tag = "R6";
      end
      if (wr && dst == 5'd0) begin
         wr = 0; tag = "R7";
      end
      chk(pc === m_pc, "R8", "pc", pc, m_pc);
      chk(wb_en === wr, tag, "wb_en", {31'd0, wb_en}, {31'd0, wr});
      if (wr) begin
         chk(wb_idx === dst, tag, "wb_idx R10", {27'd0, wb_idx}, {27'd0, dst});
         chk(wb_data === res, tag, "wb_data R10", wb_data, res);
      end
      chk(st_en === st, tag, "st_en", {31'd0, st_en}, {31'd0, st});
      if (st) begin
         chk(st_addr === addr, "R6", "st_addr", st_addr, addr);
         chk(st_data === b, "R6", "st_data", st_data, b);
      end
      if (wr) m_rf[dst] = res;
      if (st) m_dm[addr[7:2]] = b;
      m_pc = m_pc + 32'd4;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      @(negedge clk);
      // directed: R1 field split and R4 decrement word
      build_prog(32'h1234_5678);
      prog[0] = 32'h2210FFFF;
      prog[1] = 32'h2210FFFF;
      load_and_reset();
      chk(wb_en && wb_idx == 5'd16, "R1", "decrement target", {27'd0, wb_idx}, 32'd16);
      chk(wb_data === 32'hFFFF_FFFF, "R4", "first decrement", wb_data, 32'hFFFF_FFFF);
      @(negedge clk); #1;
      chk(wb_data === 32'hFFFF_FFFE, "R4", "second decrement R10", wb_data, 32'hFFFF_FFFE);
      // rerun same program under the reference interpreter
      load_and_reset();
      for (int c = 0; c < RUN_CYC; c++) begin
         step_check();
         @(negedge clk); #1;
      end
      for (int r = 0; r < 3; r++) begin
         build_prog(32'hACE1_0000 + 32'(r) * 32'h9E37_79B9);
         load_and_reset();
         for (int c = 0; c < RUN_CYC; c++) begin
            step_check();
            @(negedge clk); #1;
         end
      end
      summary();
   end

endmodule